// File: doc/BRIEF.md
# Phase-Framed DC-Balanced Word Serializer

This block turns a parallel pixel stream into a serial stream of 20-bit words, one word per pixel period. Each pixel carries 18 video bits, 9 control bits and a data-enable flag. When data-enable is high, the pixel is a video slot. Its 18 symbols are sent with a type tag and an inversion flag. The inversion is chosen by a running-disparity tracker, so that the video payload stays DC-balanced over time. When data-enable is low, the pixel is a control slot. Its control bits are spread over the word: five of them are sent three times each so that a receiver can vote out a single bit error, and four are sent once each.

Each change of phase is framed by a fixed transition word. The block decides which control samples it throws away near a boundary. Input pixels pass through a two-deep lookahead pipeline, so a coming rise of data-enable is known before the word for the current slot is formed. A control slot that lies within two slots of any video slot is not sampled. The slot right before video carries the control-to-video transition word. The slot right after video carries the video-to-control transition word. Any other suppressed slot repeats the last control value that was sampled.

The block runs on one clock. `bit_en` pulses once per serial bit. `pix_en` pulses once per pixel, in the bit slot where the word bit counter reads 15, which gives exactly 20 `bit_en` per `pix_en`. Serial bits leave least significant bit first, and `word_start_o` flags bit 0 of each word.

Top module: `phase_serializer`

## Requirements
- R1: Every serial word is 20 bits. Bit 0 leaves first. `word_start_o` is high exactly while bit 0 is on `ser_o`, and the next word follows bit 19 with no idle bit.
- R2: A video word has bit 0 = 1 (type tag), bit 1 = inversion flag, and bits 2..19 = the 18 video bits, each inverted when the flag is 1.
- R3: Symbol disparity is (ones − zeros) of the 18 video bits. The payload is inverted exactly when the running disparity and the symbol disparity are both nonzero and have the same sign. The running disparity then adds the disparity of the symbols as sent. It is 0 after reset and only video slots change it.
- R4: A control word has bit 0 = 0. Control bit j (j = 0..4) fills bits 3j+1, 3j+2 and 3j+3. Control bits 5..8 fill bits 16..19.
- R5: A control slot's own control bits are sampled only when data-enable is low for that slot, for the two slots before it and for the two slots after it. Any other control slot that does not carry a transition word repeats the last sampled control value, which is 0 after reset. Control inputs of video slots have no effect.
- R6: The last control slot before a video slot sends 20'h5A5A6. The first control slot after a video slot sends 20'hA5A5A. When one control slot sits between two video slots, 20'h5A5A6 wins. Both patterns hold ten ones, have bit 0 = 0, and have an unequal bit triple in bits 1..3, so neither can appear as a data word.
- R7: The word for a pixel sampled on a `pix_en` begins on the fourth word boundary after that `pix_en`. That is 3 pixel periods plus 4 bit times after the sample.
- R8: During and after reset, `ser_o` is 0 and `word_start_o` is 1. The words sent before the first pipelined pixel are all-zero control words.
- R9: While `bit_en` is low, `ser_o` and `word_start_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One pulse per serial bit |
| pix_en | input | 1 | One pulse per pixel, in bit slot 15 of the word |
| de_i | input | 1 | Data-enable: 1 video slot, 0 control slot |
| vid_i | input | 18 | Video bits |
| ctl_i | input | 9 | Control bits |
| ser_o | output | 1 | Serial data, least significant bit first |
| word_start_o | output | 1 | High while bit 0 of a word is on ser_o |

## Verification
A stimulus table drives a run of sampled control slots, then a video burst and a long control gap. It follows with a single-slot control gap between two video slots and a tail of control slots. This separates sampled, repeated and transition-carrying control slots, and it checks which transition word wins when both apply. Inside the video slots, the patterns are all-ones, all-zeros, near-all-ones, balanced and lightly weighted payloads. These tell apart the cases where the running disparity is zero, where it has the same sign as the payload, and where it has the opposite sign. Garbage on the control pins during suppressed and video slots, and on the video pins during control slots, shows that those inputs are ignored. The decoded stream is compared word by word at the fixed latency, and directed checks cover reset output, the warm-up words and a stall of the bit enable.

// File: rtl/ser_pkg.sv
// Shared constants and types for the phase-framed word serializer.
// Assumes the default widths; the modules take them as parameters.
package ser_pkg;
    localparam int VID_BITS  = 18;
    localparam int CTL_TRIPS = 5;   // control bits sent three times
    localparam int CTL_SINGS = 4;   // control bits sent once
    localparam int CTL_BITS  = CTL_TRIPS + CTL_SINGS;
    localparam int WORD_BITS = 20;
    localparam int LOOKAHEAD = 2;

    localparam logic [WORD_BITS-1:0] PAT_TO_VIDEO = 20'h5A5A6;
    localparam logic [WORD_BITS-1:0] PAT_TO_CTRL  = 20'hA5A5A;

    // Classification of the slot currently being framed.
    typedef enum logic [2:0] {
        K_VIDEO    = 3'd0,
        K_CTL_NEW  = 3'd1,
        K_CTL_HOLD = 3'd2,
        K_TO_CTRL  = 3'd3,
        K_TO_VIDEO = 3'd4
    } slot_kind_e;
endpackage

// File: rtl/ser_phase_window.sv
// Lookahead input pipeline and slot classifier.
// Holds LOOK future pixels ahead of the current slot and LOOK past
// data-enable values. It decides whether the current slot is video,
// a sampled control slot, a repeated control slot or a transition slot,
// and it keeps the last sampled control value.
// Assumes LOOK >= 2 and that pix_en advances one pixel.
module ser_phase_window
    import ser_pkg::*;
#(
    parameter int VID_W = VID_BITS,
    parameter int CTL_W = CTL_BITS,
    parameter int LOOK  = LOOKAHEAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             de_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic [CTL_W-1:0] ctl_i,
    output slot_kind_e       kind_o,
    output logic [VID_W-1:0] cur_vid_o,
    output logic [CTL_W-1:0] cur_ctl_o
);
    localparam int DEPTH = LOOK + 1;

    logic             pipe_de  [DEPTH];
    logic [VID_W-1:0] pipe_vid [DEPTH];
    logic [CTL_W-1:0] pipe_ctl [DEPTH];
    logic [LOOK-1:0]  past_de;    // [0] = previous slot
    logic [LOOK-1:0]  ahead_de;   // [0] = next slot
    logic [CTL_W-1:0] held_q;
    slot_kind_e       kind;

    // Shift the pixel pipeline and the past data-enable history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_de[i]  <= 1'b0;
                pipe_vid[i] <= '0;
                pipe_ctl[i] <= '0;
            end
            past_de <= '0;
        end else if (pix_en) begin
            pipe_de[0]  <= de_i;
            pipe_vid[0] <= vid_i;
            pipe_ctl[0] <= ctl_i;
            for (int i = 1; i < DEPTH; i++) begin
                pipe_de[i]  <= pipe_de[i-1];
                pipe_vid[i] <= pipe_vid[i-1];
                pipe_ctl[i] <= pipe_ctl[i-1];
            end
            past_de[0] <= pipe_de[LOOK];
            for (int i = 1; i < LOOK; i++) begin
                past_de[i] <= past_de[i-1];
            end
        end
    end

    // Gather the lookahead data-enables, nearest slot first.
    for (genvar j = 0; j < LOOK; j++) begin : g_ahead
        assign ahead_de[j] = pipe_de[LOOK-1-j];
    end

    // Classify the current slot; control-to-video framing has priority.
    always_comb begin
        if (pipe_de[LOOK])                  kind = K_VIDEO;
        else if (ahead_de[0])               kind = K_TO_VIDEO;
        else if (past_de[0])                kind = K_TO_CTRL;
        else if ((|ahead_de) || (|past_de)) kind = K_CTL_HOLD;
        else                                kind = K_CTL_NEW;
    end

    // Keep the last control value that was actually sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (pix_en && kind == K_CTL_NEW) begin
            held_q <= pipe_ctl[LOOK];
        end
    end

    assign kind_o    = kind;
    assign cur_vid_o = pipe_vid[LOOK];
    assign cur_ctl_o = (kind == K_CTL_NEW) ? pipe_ctl[LOOK] : held_q;

    // R5: slots that are not sampled leave the stored control value alone.
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && kind != K_CTL_NEW) |=> $stable(held_q));

    // R6: a slot whose successor is video is never framed as leaving video.
    p_c2v_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ahead_de[0] && kind != K_VIDEO) |-> (kind != K_TO_CTRL));
endmodule

// File: rtl/ser_video_balancer.sv
// Running-disparity DC balancer for the video payload.
// It counts the ones in the payload and inverts the payload when that
// pushes the running disparity toward zero. It updates the disparity on
// each fired video slot. Only the payload is tracked; tag bits and
// control words are ignored.
module ser_video_balancer #(
    parameter int VID_W = ser_pkg::VID_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [VID_W-1:0] sym_i,
    output logic [VID_W-1:0] sym_o,
    output logic             inv_o
);
    localparam int RD_W = $clog2(2 * VID_W + 1) + 1;
    localparam logic signed [RD_W-1:0] RD_LIM = RD_W'(VID_W);

    logic [RD_W-1:0]        pop;
    logic signed [RD_W-1:0] dsym;
    logic signed [RD_W-1:0] rd_q;
    logic signed [RD_W-1:0] rd_next;
    logic                   inv;

    // Count the ones in the raw payload.
    always_comb begin
        pop = '0;
        for (int i = 0; i < VID_W; i++) begin
            pop = pop + RD_W'(sym_i[i]);
        end
    end

    // Pick the polarity and the next running disparity.
    always_comb begin
        dsym    = $signed((pop << 1) - RD_W'(VID_W));
        inv     = (rd_q != '0) && (dsym != '0) && (rd_q[RD_W-1] == dsym[RD_W-1]);
        rd_next = inv ? (rd_q - dsym) : (rd_q + dsym);
    end

    // Update the running disparity on each video slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (fire_i) begin
            rd_q <= rd_next;
        end
    end

    assign sym_o = inv ? ~sym_i : sym_i;
    assign inv_o = inv;

    // R3: the running disparity never leaves one payload's swing.
    p_disp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q <= RD_LIM) && (rd_q >= -RD_LIM));

    // R3: non-video slots leave the running disparity alone.
    p_disp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> $stable(rd_q));
endmodule

// File: rtl/ser_word_former.sv
// Builds the 20-bit word for the current slot from its kind.
// A video word is tag, inversion flag and payload. A control word is
// the tag, then triplicated and single control bits. A transition word
// is one of two fixed patterns.
// Assumes WORD_W = VID_W + 2 = 1 + 3*TRIP_N + SING_N.
module ser_word_former
    import ser_pkg::*;
#(
    parameter int VID_W  = VID_BITS,
    parameter int TRIP_N = CTL_TRIPS,
    parameter int SING_N = CTL_SINGS,
    parameter int WORD_W = WORD_BITS,
    parameter logic [WORD_W-1:0] PAT_V = PAT_TO_VIDEO,
    parameter logic [WORD_W-1:0] PAT_C = PAT_TO_CTRL
) (
    input  slot_kind_e                kind_i,
    input  logic [VID_W-1:0]          sym_i,
    input  logic                      inv_i,
    input  logic [TRIP_N+SING_N-1:0]  ctl_i,
    output logic [WORD_W-1:0]         word_o
);
    localparam int SING_BASE = 1 + 3 * TRIP_N;

    logic [WORD_W-1:0] vid_word;
    logic [WORD_W-1:0] ctl_word;

    assign vid_word = {sym_i, inv_i, 1'b1};
    assign ctl_word[0] = 1'b0;

    // Spread each voted control bit over three neighbouring positions.
    for (genvar g = 0; g < TRIP_N; g++) begin : g_trip
        assign ctl_word[1 + 3*g +: 3] = {3{ctl_i[g]}};
    end

    // Place each single control bit after the voted group.
    for (genvar g = 0; g < SING_N; g++) begin : g_sing
        assign ctl_word[SING_BASE + g] = ctl_i[TRIP_N + g];
    end

    // Select the word by slot kind.
    always_comb begin
        case (kind_i)
            K_VIDEO:    word_o = vid_word;
            K_TO_VIDEO: word_o = PAT_V;
            K_TO_CTRL:  word_o = PAT_C;
            default:    word_o = ctl_word;
        endcase
    end
endmodule

// File: rtl/ser_word_shifter.sv
// Word staging register and LSB-first output shifter.
// The next word is staged on pix_en. The shifter loads the staged word
// on the bit enable that follows bit 19, so words leave back to back.
// Assumes one pix_en per WORD_W bit enables, away from the load slot.
module ser_word_shifter #(
    parameter int WORD_W = ser_pkg::WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              pix_en,
    input  logic [WORD_W-1:0] word_i,
    output logic              ser_o,
    output logic              word_start_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    // Stage the word formed for this pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= '0;
        else if (pix_en) stage_q <= word_i;
    end

    // Count bits and shift, loading the staged word after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (bit_en) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                sh_q  <= stage_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
            end
        end
    end

    assign ser_o        = sh_q[0];
    assign word_start_o = (cnt_q == '0);

    // R1: the bit counter stays inside one word.
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R1: the word after bit 19 is the staged one, with no idle bit.
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cnt_q == LAST) |=> (sh_q == $past(stage_q) && word_start_o));

    // R9: without a bit enable the output stands still.
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sh_q) && $stable(cnt_q)));
endmodule

// File: rtl/phase_serializer.sv
// Top of the phase-framed DC-balanced word serializer.
// Pipeline and classifier -> video balancer -> word former -> shifter.
// Assumes bit_en / pix_en timing as stated in the shifter header.
module phase_serializer
    import ser_pkg::*;
#(
    parameter int VID_W  = VID_BITS,
    parameter int TRIP_N = CTL_TRIPS,
    parameter int SING_N = CTL_SINGS,
    parameter int LOOK   = LOOKAHEAD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_en,
    input  logic                     pix_en,
    input  logic                     de_i,
    input  logic [VID_W-1:0]         vid_i,
    input  logic [TRIP_N+SING_N-1:0] ctl_i,
    output logic                     ser_o,
    output logic                     word_start_o
);
    localparam int CTL_W  = TRIP_N + SING_N;
    localparam int WORD_W = VID_W + 2;

    slot_kind_e        kind;
    logic [VID_W-1:0]  cur_vid;
    logic [CTL_W-1:0]  cur_ctl;
    logic [VID_W-1:0]  enc_sym;
    logic              enc_inv;
    logic [WORD_W-1:0] next_word;

    ser_phase_window #(.VID_W(VID_W), .CTL_W(CTL_W), .LOOK(LOOK)) u_window (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .de_i(de_i), .vid_i(vid_i), .ctl_i(ctl_i),
        .kind_o(kind), .cur_vid_o(cur_vid), .cur_ctl_o(cur_ctl)
    );

    ser_video_balancer #(.VID_W(VID_W)) u_balance (
        .clk(clk), .rst_n(rst_n),
        .fire_i(pix_en && kind == K_VIDEO),
        .sym_i(cur_vid), .sym_o(enc_sym), .inv_o(enc_inv)
    );

    ser_word_former #(.VID_W(VID_W), .TRIP_N(TRIP_N), .SING_N(SING_N),
                      .WORD_W(WORD_W)) u_former (
        .kind_i(kind), .sym_i(enc_sym), .inv_i(enc_inv),
        .ctl_i(cur_ctl), .word_o(next_word)
    );

    ser_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pix_en(pix_en),
        .word_i(next_word), .ser_o(ser_o), .word_start_o(word_start_o)
    );

    // R2: video words carry the video tag and the chosen polarity.
    p_video_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_VIDEO) |-> (next_word[0] && next_word[1] == enc_inv));

    // R4: control words carry the control tag.
    p_ctl_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_CTL_NEW || kind == K_CTL_HOLD) |-> !next_word[0]);

    // R6: transition words are balanced.
    p_trans_bal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_TO_VIDEO || kind == K_TO_CTRL) |->
            ($countones(next_word) == WORD_W / 2));
endmodule

// File: tb/sim_phase_serializer.sv
module sim_phase_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int NV    = 28;
    localparam int NPAD  = 5;
    localparam int NWARM = 3;

    // {de, vid[17:0], ctl[8:0], kind[2:0], inv, expected ctl[8:0]}
    // kind: 0 video, 1 sampled control, 2 repeated control, 3 to-control, 4 to-video
    localparam logic [40:0] TBL [NV] = '{
        {1'b0, 18'h2468A, 9'h1A5, 3'd1, 1'b0, 9'h1A5},
        {1'b0, 18'h13579, 9'h0F3, 3'd1, 1'b0, 9'h0F3},
        {1'b0, 18'h3C3C3, 9'h155, 3'd1, 1'b0, 9'h155},
        {1'b0, 18'h00FFF, 9'h0AA, 3'd1, 1'b0, 9'h0AA},
        {1'b0, 18'h3FFFF, 9'h1FF, 3'd2, 1'b0, 9'h0AA},
        {1'b0, 18'h15555, 9'h123, 3'd4, 1'b0, 9'h000},
        {1'b1, 18'h3FFFF, 9'h1FF, 3'd0, 1'b0, 9'h000},
        {1'b1, 18'h3FFFF, 9'h0F0, 3'd0, 1'b1, 9'h000},
        {1'b1, 18'h00000, 9'h1FF, 3'd0, 1'b0, 9'h000},
        {1'b1, 18'h00001, 9'h155, 3'd0, 1'b1, 9'h000},
        {1'b0, 18'h2468A, 9'h0FF, 3'd3, 1'b0, 9'h000},
        {1'b0, 18'h11111, 9'h111, 3'd2, 1'b0, 9'h0AA},
        {1'b0, 18'h22222, 9'h001, 3'd1, 1'b0, 9'h001},
        {1'b0, 18'h33333, 9'h100, 3'd1, 1'b0, 9'h100},
        {1'b0, 18'h0F0F0, 9'h1F0, 3'd2, 1'b0, 9'h100},
        {1'b0, 18'h12345, 9'h007, 3'd4, 1'b0, 9'h000},
        {1'b1, 18'h3FFFE, 9'h1AB, 3'd0, 1'b0, 9'h000},
        {1'b0, 18'h3FFFF, 9'h155, 3'd4, 1'b0, 9'h000},
        {1'b1, 18'h2AAAA, 9'h0F0, 3'd0, 1'b0, 9'h000},
        {1'b1, 18'h3F000, 9'h1FF, 3'd0, 1'b0, 9'h000},
        {1'b0, 18'h0ABCD, 9'h0C3, 3'd3, 1'b0, 9'h000},
        {1'b0, 18'h1DCBA, 9'h03C, 3'd2, 1'b0, 9'h100},
        {1'b0, 18'h2F0F0, 9'h18F, 3'd1, 1'b0, 9'h18F},
        {1'b0, 18'h00000, 9'h070, 3'd1, 1'b0, 9'h070},
        {1'b0, 18'h3FFFF, 9'h1C7, 3'd1, 1'b0, 9'h1C7},
        {1'b0, 18'h1E1E1, 9'h038, 3'd1, 1'b0, 9'h038},
        {1'b0, 18'h05050, 9'h000, 3'd1, 1'b0, 9'h000},
        {1'b0, 18'h0A0A0, 9'h1FF, 3'd1, 1'b0, 9'h1FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b1;
    logic        pix_en = 1'b0;
    logic        de_i = 1'b0;
    logic [17:0] vid_i = '0;
    logic [8:0]  ctl_i = '0;
    logic        ser_o;
    logic        word_start_o;

    int checks = 0;
    int fails  = 0;

    logic [19:0] capw [64];
    logic [19:0] acc = '0;
    int ncap = 0;
    int nb = 0;
    int gaps = 0;
    bit cap_on = 1'b0;

    phase_serializer u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pix_en(pix_en),
        .de_i(de_i), .vid_i(vid_i), .ctl_i(ctl_i),
        .ser_o(ser_o), .word_start_o(word_start_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected word from the requirement formats (R2, R4, R6).
    function automatic logic [19:0] mk_word(input logic [2:0] kind, input logic inv,
                                            input logic [17:0] vid, input logic [8:0] c);
        logic [19:0] w;
        w = '0;
        case (kind)
            3'd0: w = {vid ^ {18{inv}}, inv, 1'b1};
            3'd3: w = 20'hA5A5A;
            3'd4: w = 20'h5A5A6;
            default: begin
                for (int j = 0; j < 5; j++) begin
                    w[3*j+1] = c[j];
                    w[3*j+2] = c[j];
                    w[3*j+3] = c[j];
                end
                for (int j = 0; j < 4; j++) w[16+j] = c[5+j];
            end
        endcase
        return w;
    endfunction

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Collect serial words bit by bit, split at each word start.
    always @(negedge clk) begin
        if (cap_on && bit_en) begin
            if (word_start_o) begin
                if (nb == 20) begin
                    if (ncap < 64) capw[ncap] = acc;
                    ncap++;
                end else if (ncap > 0) begin
                    gaps++;
                end
                acc = '0;
                nb = 0;
            end
            if (nb < 20) acc[nb] = ser_o;
            nb++;
        end
    end

    initial begin
        logic so_hold;
        logic ws_hold;
        repeat (4) @(negedge clk);
        check("R8 reset ser_o", {19'd0, ser_o}, 20'd0);
        check("R8 reset word_start", {19'd0, word_start_o}, 20'd1);
        rst_n = 1'b1;

        // Line up pix_en with bit slot 15 of the word.
        do @(negedge clk); while (!word_start_o);
        repeat (15) @(negedge clk);

        for (int i = 0; i < NV + NPAD; i++) begin
            logic [40:0] e;
            e = (i < NV) ? TBL[i] : '0;
            de_i  = e[40];
            vid_i = e[39:22];
            ctl_i = e[21:13];
            pix_en = 1'b1;
            @(negedge clk);
            pix_en = 1'b0;
            if (i == 0) cap_on = 1'b1;
            repeat (19) @(negedge clk);
        end
        cap_on = 1'b0;

        checks++;
        if (ncap < NV + NWARM) begin
            fails++;
            $display("FAIL R7 word count: got %0d expected %0d", ncap, NV + NWARM);
        end

        for (int k = 0; k < NWARM; k++) begin
            check("R8 warm-up word", capw[k], 20'd0);
        end

        for (int i = 0; i < NV; i++) begin
            logic [40:0] e;
            string tag;
            e = TBL[i];
            case (e[12:10])
                3'd0:    tag = $sformatf("R2 R3 R7 video slot %0d", i);
                3'd1:    tag = $sformatf("R4 R5 R7 sampled slot %0d", i);
                3'd2:    tag = $sformatf("R5 repeated slot %0d", i);
                default: tag = $sformatf("R6 transition slot %0d", i);
            endcase
            check(tag, capw[i + NWARM], mk_word(e[12:10], e[9], e[39:22], e[8:0]));
        end

        checks++;
        if (gaps != 0) begin
            fails++;
            $display("FAIL R1 word spacing: got %0d misaligned starts expected 0", gaps);
        end

        // R9: a stalled bit enable freezes the output.
        @(negedge clk);
        bit_en = 1'b0;
        so_hold = ser_o;
        ws_hold = word_start_o;
        repeat (5) @(negedge clk);
        check("R9 stall ser_o", {19'd0, ser_o}, {19'd0, so_hold});
        check("R9 stall word_start", {19'd0, word_start_o}, {19'd0, ws_hold});
        bit_en = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule